// File: doc/BRIEF.md
# Register-Mapped 3x3 Convolution Unit

This peripheral computes one output pixel of a 3x3 convolution on each request from a processor. Software loads the nine pixels of the current window into operand registers and writes a start command to the control register. It then either polls the finish bit in the status register or waits for the interrupt line, and reads the weighted sum from the result register. The nine kernel weights are elaboration-time constants, so every multiplier reduces to a few shifts and adds.

The window layout follows the order in which a driver walks the image. Position 0 is the pixel at row r and column c. Positions 1 and 2 step back to columns c-1 and c-2 on the same row. Positions 3 to 5 repeat that column order on row r-1, and positions 6 to 8 repeat it on row r-2. The product tree settles within one clock period, so a result is ready one cycle after the start command.

Top module: `kconv_periph`

## Requirements
- R1: After reset, the finish flag, the interrupt output, the result register and every operand register are 0.
- R2: Bus offsets 1 to 9 hold the window operands for positions 0 to 8. Each operand is 8-bit unsigned. A write keeps bits [7:0] of the write data, and a read returns the operand zero-extended.
- R3: The result at offset 11 is the sum over positions 0..8 of operand times weight, with default weights 1,3,1,0,5,0,2,1,2. The result is 16 bits wide and zero-extended on reads.
- R4: A write of 0x2 to offset 0 while the block is idle is a start. The finish flag reads 0 in the cycle after the write edge and reads 1 one clock later. Finish is status bit 0 at offset 10, and the interrupt output always equals it.
- R5: Once set, the finish flag and the result hold until the next accepted start or clear command.
- R6: A control write with bit 0 set is a clear. It aborts any computation, drops the finish flag and zeroes the result. Clear takes priority over start when both bits are set (0x3).
- R7: A start write that arrives in the cycle while a computation is in flight is ignored.
- R8: An operand write made during the compute cycle does not alter the result in flight. It takes effect at the next start.
- R9: Control writes with bits [1:0] equal to 0, and writes to offsets 10 and 11, change neither the finish flag nor the result.
- R10: Reads of offset 0 and of offsets 12 to 15 return 0.
- R11: A window of all 255s gives 3825, with no truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 4 | Register offset |
| wr_en_i | input | 1 | Write strobe, sampled on the rising edge |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Completion interrupt, equal to the finish flag |

## Verification
Each random window is compared with a weighted sum computed in the bench.

- **Weight placement:** the random windows catch a swapped or misplaced weight.
- **Zero-weight positions:** a window that is zero except at positions 3 and 5 shows whether those weights really contribute nothing.
- **Adder width:** an all-255 window probes the adder width at its largest value.
- **Command timing:** back-to-back start and operand writes separate a block that ignores a busy start or samples operands late from a correct one.
- **Clear priority:** a 0x3 command shows which command wins.

// File: rtl/kconv_pkg.sv
package kconv_pkg;
  localparam int unsigned TAPS      = 9;
  localparam int unsigned OFF_CTRL  = 0;
  localparam int unsigned OFF_OPND0 = 1;
  localparam int unsigned OFF_STAT  = 10;
  localparam int unsigned OFF_RES   = 11;
  localparam int unsigned CMD_CLR   = 0;
  localparam int unsigned CMD_GO    = 1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CALC = 1'b1
  } calc_state_e;
endpackage

// File: rtl/kconv_cmd.sv
module kconv_cmd
  import kconv_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        cmd_i,
  output logic              clr_o,
  output logic              go_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);

  logic ctrl_hit;

  assign ctrl_hit = wr_en_i && (addr_i == A_CTRL);
  // clear wins over start when both bits are set
  assign clr_o    = ctrl_hit && cmd_i[CMD_CLR];
  assign go_o     = ctrl_hit && cmd_i[CMD_GO] && !cmd_i[CMD_CLR];
endmodule

// File: rtl/kconv_opnd_regs.sv
module kconv_opnd_regs
  import kconv_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PIX_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [PIX_W-1:0]            wr_data_i,
  output logic [TAPS-1:0][PIX_W-1:0]  opnd_o
);
  for (genvar g = 0; g < TAPS; g++) begin : g_opnd
    localparam logic [ADDR_W-1:0] MY_OFF = ADDR_W'(OFF_OPND0 + g);
    logic             load_en;
    logic [PIX_W-1:0] pix_q;

    assign load_en = wr_en_i && (addr_i == MY_OFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pix_q <= '0;
      end else if (load_en) begin
        pix_q <= wr_data_i;
      end
    end

    assign opnd_o[g] = pix_q;
  end
endmodule

// File: rtl/kconv_mac.sv
module kconv_mac
  import kconv_pkg::*;
#(
  parameter int unsigned              PIX_W  = 8,
  parameter int unsigned              COEF_W = 8,
  parameter int unsigned              RES_W  = 16,
  parameter logic [TAPS*COEF_W-1:0]   KERNEL = '0
) (
  input  logic [TAPS-1:0][PIX_W-1:0] opnd_i,
  output logic [RES_W-1:0]           sum_o
);
  localparam int unsigned PROD_W = PIX_W + COEF_W;

  logic [TAPS-1:0][PROD_W-1:0] prod;
  logic [RES_W-1:0]            acc;

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    localparam logic [COEF_W-1:0] WEIGHT = KERNEL[g*COEF_W +: COEF_W];
    assign prod[g] = PROD_W'(opnd_i[g]) * PROD_W'(WEIGHT);
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + RES_W'(prod[i]);
    end
  end

  assign sum_o = acc;
endmodule

// File: rtl/kconv_ctrl.sv
module kconv_ctrl
  import kconv_pkg::*;
#(
  parameter int unsigned RES_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             go_i,
  input  logic [RES_W-1:0] sum_i,
  output logic             idle_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  calc_state_e      state_q, state_d;
  logic             done_q, done_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             res_en;

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    res_d   = res_q;
    case (state_q)
      ST_IDLE: begin
        if (go_i) begin
          state_d = ST_CALC;
          done_d  = 1'b0;
        end
      end
      ST_CALC: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        res_d   = sum_i;
      end
      default: state_d = ST_IDLE;
    endcase
    if (clr_i) begin
      state_d = ST_IDLE;
      done_d  = 1'b0;
      res_d   = '0;
    end
  end

  assign res_en = clr_i || (state_q == ST_CALC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      res_q   <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign idle_o   = (state_q == ST_IDLE);
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/kconv_periph.sv
module kconv_periph
  import kconv_pkg::*;
#(
  parameter int unsigned            ADDR_W = 4,
  parameter int unsigned            BUS_W  = 32,
  parameter int unsigned            PIX_W  = 8,
  parameter int unsigned            COEF_W = 8,
  parameter int unsigned            RES_W  = 16,
  parameter logic [TAPS*COEF_W-1:0] KERNEL = {8'd2, 8'd1, 8'd2, 8'd0, 8'd5,
                                              8'd0, 8'd1, 8'd3, 8'd1}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BUS_W-1:0]  wr_data_i,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFF_RES);

  logic                       rst_meta_n, rst_sync_n;
  logic                       cmd_clr, cmd_go;
  logic [TAPS-1:0][PIX_W-1:0] opnd;
  logic [RES_W-1:0]           mac_sum;
  logic                       calc_idle;
  logic                       done;
  logic [RES_W-1:0]           result;
  logic                       unused_wdata;

  assign unused_wdata = ^wr_data_i[BUS_W-1:PIX_W];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  kconv_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .cmd_i   (wr_data_i[1:0]),
    .clr_o   (cmd_clr),
    .go_o    (cmd_go)
  );

  kconv_opnd_regs #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_opnd (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i[PIX_W-1:0]),
    .opnd_o    (opnd)
  );

  kconv_mac #(
    .PIX_W  (PIX_W),
    .COEF_W (COEF_W),
    .RES_W  (RES_W),
    .KERNEL (KERNEL)
  ) u_mac (
    .opnd_i (opnd),
    .sum_o  (mac_sum)
  );

  kconv_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .clr_i    (cmd_clr),
    .go_i     (cmd_go),
    .sum_i    (mac_sum),
    .idle_o   (calc_idle),
    .done_o   (done),
    .result_o (result)
  );

  always_comb begin
    rd_data_o = '0;
    if (addr_i == A_STAT) begin
      rd_data_o[0] = done;
    end else if (addr_i == A_RES) begin
      rd_data_o[RES_W-1:0] = result;
    end else begin
      for (int i = 0; i < TAPS; i++) begin
        if (addr_i == ADDR_W'(OFF_OPND0 + i)) begin
          rd_data_o[PIX_W-1:0] = opnd[i];
        end
      end
    end
  end

  assign irq_o = done;
endmodule

// File: rtl/kconv_periph_chk.sv
module kconv_periph_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned RES_W  = 16
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        cmd_i,
  input logic              irq_i,
  input logic [RES_W-1:0]  result_i,
  input logic              idle_i
);
  logic ctrl_wr, go_acc;

  assign ctrl_wr = wr_en_i && (addr_i == '0);
  assign go_acc  = ctrl_wr && (cmd_i == 2'b10) && idle_i;

  p_start_sequence_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    go_acc |=> (!irq_i ##1 irq_i));

  p_finish_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (irq_i && !ctrl_wr) |=> (irq_i && $stable(result_i)));

  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ctrl_wr && cmd_i[0]) |=> (!irq_i && (result_i == '0)));

  p_single_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !idle_i |=> idle_i);

  p_null_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (idle_i && !(ctrl_wr && (cmd_i != 2'b00))) |=> ($stable(irq_i) && $stable(result_i)));
endmodule

bind kconv_periph kconv_periph_chk #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .cmd_i    (wr_data_i[1:0]),
  .irq_i    (irq_o),
  .result_i (result),
  .idle_i   (calc_idle)
);

// File: tb/kconv_periph_tb.sv
module kconv_periph_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wen = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int nchk = 0;
  int nfail = 0;
  bit done_flag = 0;
  int win[9];
  localparam int WT[9] = '{1, 3, 1, 0, 5, 0, 2, 1, 2};

  always #4 clk = ~clk;

  kconv_periph u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .addr_i    (addr),
    .wr_en_i   (wen),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .irq_o     (irq)
  );

  function automatic int ref_sum();
    int s = 0;
    for (int i = 0; i < 9; i++) s += win[i] * WT[i];
    return s;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr  = 4'(a);
    wdata = 32'(d);
    wen   = 1'b1;
    @(negedge clk);
    wen   = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 4'(a);
    #1;
    v = int'(rdata);
  endtask

  task automatic load();
    for (int i = 0; i < 9; i++) wr(i + 1, win[i]);
  endtask

  task automatic run_check(input string tag);
    int v;
    wr(0, 2);
    chk({tag, " R4 finish low after start edge"}, irq, 0);
    @(negedge clk);
    chk({tag, " R4 irq one cycle later"}, irq, 1);
    rd(10, v);
    chk({tag, " R4 status bit0"}, v, 1);
    rd(11, v);
    chk({tag, " R3 result"}, v, ref_sum());
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    int v, r;
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 0);
    rd(10, v); chk("R1 status", v, 0);
    rd(11, v); chk("R1 result", v, 0);
    rd(5, v);  chk("R1 operand", v, 0);

    // R2 operand width and readback
    wr(1, 32'h1AB);
    rd(1, v); chk("R2 low byte kept", v, 32'hAB);
    wr(9, 32'hFFFF_FF07);
    rd(9, v); chk("R2 position 8", v, 7);

    // R10 unmapped reads
    rd(0, v);  chk("R10 ctrl reads 0", v, 0);
    rd(12, v); chk("R10 offset 12", v, 0);
    rd(15, v); chk("R10 offset 15", v, 0);

    // R3 directed window
    win = '{3, 21, 19, 22, 20, 13, 16, 14, 7};
    load();
    run_check("directed");
    chk("R3 known value 245", ref_sum(), 245);

    // R5 hold over idle cycles and operand writes
    wr(2, 99);
    repeat (5) @(negedge clk);
    chk("R5 irq held", irq, 1);
    rd(11, v); chk("R5 result held", v, 245);

    // R9 null command and writes to read-only offsets
    wr(0, 0); wr(0, 4); wr(10, 0); wr(11, 32'h1234);
    @(negedge clk);
    chk("R9 irq unchanged", irq, 1);
    rd(11, v); chk("R9 result unchanged", v, 245);

    // R6 clear
    wr(0, 1);
    chk("R6 irq cleared", irq, 0);
    rd(11, v); chk("R6 result zeroed", v, 0);

    // R6 clear priority over start (0x3)
    win = '{3, 21, 19, 22, 20, 13, 16, 14, 7};
    load();
    wr(0, 3);
    @(negedge clk);
    chk("R6 0x3 does not start", irq, 0);
    rd(11, v); chk("R6 0x3 result zero", v, 0);

    // R11 all-max window
    for (int i = 0; i < 9; i++) win[i] = 255;
    load();
    run_check("max R11");
    rd(11, v); chk("R11 3825", v, 3825);

    // zero-weight positions only
    win = '{0, 0, 0, 200, 0, 77, 0, 0, 0};
    load();
    run_check("zero-weight R3");

    // R7 start during computation ignored; R8 operand write during compute
    win = '{10, 21, 19, 22, 20, 13, 16, 14, 7};
    load();
    wr(0, 2);
    wr(0, 2);
    chk("R7 irq after busy start", irq, 1);
    rd(11, v); chk("R7 result", v, ref_sum());
    @(negedge clk);
    chk("R7 no second computation", irq, 1);

    wr(0, 2);
    r = ref_sum();
    wr(1, 200);
    rd(11, v); chk("R8 in-flight result uses old operand", v, r);
    win[0] = 200;
    run_check("R8 next start");

    // constrained random windows
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 9; i++) begin
        r = int'($urandom_range(0, 3));
        win[i] = (r == 0) ? 255 : ((r == 1) ? 0 : int'($urandom_range(0, 255)));
      end
      load();
      if ((t % 7) == 0) wr(0, 1);
      run_check("random R3");
    end

    done_flag = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule